// File: doc/BRIEF.md
# Drift-Corrected Schedule Delta Generator

This block is the tick-domain timebase of a time-aware gate schedule. Every clock cycle is one scheduler tick. The ticks are grouped into deltas. A nominal delta is 25 ticks, which is 200 ns. The block pulses a strobe at the first tick of each delta and gives the index of that delta within the schedule cycle. The index wraps after the last delta of the cycle. The gate-list lookup that consumes the index is outside this block.

The engine is armed by a start command and begins when the synchronized clock value `sync_time` reaches the programmed `start_time`. The synchronized clock is rate-corrected elsewhere, so it can drift against the local tick count. To handle this, the block keeps a correction period measured in synchronized-clock ticks, which should be set to the longest cycle time. At each period boundary it compares the synchronized ticks that elapsed with the local ticks that elapsed, and stores the opposite of that drift as a signed correction. At each later delta boundary, up to 5 ticks of this correction are taken to lengthen or shorten the next delta. Whatever is left is kept for the deltas after it. As a result, a delta lasts 200 ns only on average.

The control state machine has three states:
- Idle (`SG_IDLE`)
- Armed (`SG_ARMED`)
- Running (`SG_RUN`)

It has four named transitions:
- Arm: Idle to Armed, on a start command without a stop.
- Launch: Armed to Running, when `sync_time >= start_time`.
- Abort: Armed to Idle, on a stop command.
- Halt: Running to Idle, on a stop command.

Top module: `sched_delta_gen`

## Requirements
- R1: After reset `running`, `delta_strobe` and `delta_idx` are all 0.
- R2: After a start command the engine stays idle (`running` = 0) until a clock edge at which `sync_time >= start_time`. In the cycle after that edge `running` is 1 and `delta_strobe` is high with `delta_idx` = 0.
- R3: When no drift is present, `delta_strobe` pulses for one cycle at the first tick of every delta, and consecutive pulses are exactly 25 cycles apart.
- R4: `delta_idx` is binary. It steps by one at each new delta and returns to 0 after the value `cycle_deltas - 1`.
- R5: A correction boundary is reached when the synchronized ticks elapsed since the last boundary (or since launch) reach `corr_period`. At that boundary the drift is the elapsed synchronized ticks minus the elapsed local ticks. The negated drift is added to a signed correction. If the synchronized clock runs ahead by N ticks (N ≤ 5), the delta that begins at the next delta boundary is 25 − N ticks long.
- R6: If the synchronized clock falls behind by N ticks (N ≤ 5), the delta that begins at the next delta boundary is 25 + N ticks long.
- R7: A single delta is never adjusted by more than 5 ticks, so delta length stays within 20..30. Correction beyond 5 ticks is carried into the following deltas.
- R8: A stop command halts the engine at the next tick. After that edge, `running` is 0, `delta_idx` is 0, and no strobe occurs until the engine is started again.
- R9: A stop command while armed aborts the launch. The engine does not start even after `sync_time` passes `start_time`.
- R10: A start command while running has no effect. If start and stop arrive in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | One-cycle start (arm) command |
| stop_cmd | input | 1 | One-cycle stop command |
| sync_time | input | TIME_W | Synchronized clock value in tick units |
| start_time | input | TIME_W | Programmed start time in synchronized-clock ticks |
| corr_period | input | PERIOD_W | Correction period in synchronized-clock ticks (≥ 1) |
| cycle_deltas | input | IDX_W | Number of deltas in a schedule cycle (≥ 1) |
| delta_strobe | output | 1 | High for one cycle at the first tick of each delta |
| delta_idx | output | IDX_W | Index of the current delta within the cycle |
| running | output | 1 | High while the engine is in the Running state |

## Verification
The bench first checks that launch happens exactly on the edge where `sync_time` equals `start_time`. A comparator that is off by one would move the first strobe by a cycle.

It then pushes the synchronized clock ahead by 3 and by 13 ticks, and holds it back by 8 ticks. These cases expose:
- a drift sign that is inverted, because deltas would then lengthen instead of shorten;
- a clamp that is missing, because a single delta of 12 or 33 ticks would appear;
- a carry that is dropped, because the 20-, 20-, 22-tick sequence or the 30-, 28-tick sequence would be cut short.

Index wrap is checked with cycle lengths of 2, 3, 4 and 5. Four kinds of command were checked:
- stop while running;
- stop while armed;
- start while running;
- start and stop in the same cycle.

A design that lets these commands leak would either keep strobing or restart the delta sequence.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_ARMED = 2'd1,
        SG_RUN   = 2'd2
    } sg_state_e;
endpackage

// File: rtl/sdg_ctrl.sv
module sdg_ctrl
    import sdg_pkg::*;
#(
    parameter int TIME_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [TIME_W-1:0] sync_time,
    input  logic [TIME_W-1:0] start_time,
    output logic              launch,
    output logic              run
);
    sg_state_e state_q, state_d;
    logic      reached;

    assign reached = (sync_time >= start_time);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SG_IDLE:  if (start_cmd && !stop_cmd) state_d = SG_ARMED;
            SG_ARMED: begin
                if (stop_cmd)     state_d = SG_IDLE;
                else if (reached) state_d = SG_RUN;
            end
            SG_RUN:   if (stop_cmd) state_d = SG_IDLE;
            default:  state_d = SG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        launch = (state_q == SG_ARMED) && !stop_cmd && reached;
        run    = (state_q == SG_RUN);
    end

    // R8
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (state_q == SG_IDLE));

    // R10
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_RUN) && !stop_cmd |=> (state_q == SG_RUN));
endmodule

// File: rtl/sdg_drift_meter.sv
module sdg_drift_meter #(
    parameter int TIME_W   = 48,
    parameter int PERIOD_W = 24,
    parameter int CARRY_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic                      active,
    input  logic [TIME_W-1:0]         sync_time,
    input  logic [PERIOD_W-1:0]       corr_period,
    output logic                      boundary,
    output logic signed [CARRY_W-1:0] drift
);
    logic [TIME_W-1:0] base_q;
    logic [TIME_W-1:0] local_q;
    logic [TIME_W-1:0] elapsed;
    logic [TIME_W-1:0] period_ext;
    logic [TIME_W-1:0] diff;

    always_comb begin
        period_ext = TIME_W'(corr_period);
        elapsed    = sync_time - base_q;
        diff       = elapsed - local_q;
        boundary   = active && (elapsed >= period_ext);
        drift      = diff[CARRY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            local_q <= '0;
        end else if (launch) begin
            base_q  <= sync_time;
            local_q <= TIME_W'(1);
        end else if (boundary) begin
            base_q  <= base_q + period_ext;
            local_q <= elapsed - period_ext + TIME_W'(1);
        end else if (active) begin
            local_q <= local_q + TIME_W'(1);
        end
    end
endmodule

// File: rtl/sdg_delta_shaper.sv
module sdg_delta_shaper #(
    parameter int IDX_W   = 8,
    parameter int CARRY_W = 16,
    parameter int NOMINAL = 25,
    parameter int MAX_ADJ = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    input  logic                      halt,
    input  logic                      boundary,
    input  logic signed [CARRY_W-1:0] drift,
    input  logic [IDX_W-1:0]          cycle_deltas,
    output logic                      strobe,
    output logic [IDX_W-1:0]          idx
);
    localparam int LEN_W = $clog2(NOMINAL + MAX_ADJ + 1);
    localparam logic signed [CARRY_W-1:0] ADJ_HI = CARRY_W'(MAX_ADJ);
    localparam logic signed [CARRY_W-1:0] ADJ_LO = -ADJ_HI;
    localparam logic signed [CARRY_W-1:0] NOM_S  = CARRY_W'(NOMINAL);
    localparam logic [LEN_W-1:0] LEN_NOM = LEN_W'(NOMINAL);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(NOMINAL - MAX_ADJ);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(NOMINAL + MAX_ADJ);

    logic [LEN_W-1:0]          tick_q, len_q, new_len;
    logic [IDX_W-1:0]          idx_q;
    logic signed [CARRY_W-1:0] carry_q, carry_eff, adj, len_s;
    logic                      delta_end, last_idx;

    always_comb begin
        carry_eff = carry_q - (boundary ? drift : '0);
        if (carry_eff > ADJ_HI)      adj = ADJ_HI;
        else if (carry_eff < ADJ_LO) adj = ADJ_LO;
        else                         adj = carry_eff;
        len_s     = NOM_S + adj;
        new_len   = len_s[LEN_W-1:0];
        delta_end = (tick_q == len_q - LEN_W'(1));
        last_idx  = (idx_q == cycle_deltas - IDX_W'(1));
        strobe    = active && (tick_q == '0);
        idx       = idx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !active || halt) begin
            tick_q  <= '0;
            len_q   <= LEN_NOM;
            idx_q   <= '0;
            carry_q <= '0;
        end else if (delta_end) begin
            tick_q  <= '0;
            len_q   <= new_len;
            carry_q <= carry_eff - adj;
            idx_q   <= last_idx ? '0 : idx_q + IDX_W'(1);
        end else begin
            tick_q  <= tick_q + LEN_W'(1);
            carry_q <= carry_eff;
        end
    end

    // R7
    len_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_MIN) && (len_q <= LEN_MAX));

    // R3
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/sched_delta_gen.sv
module sched_delta_gen #(
    parameter int TIME_W   = 48,
    parameter int PERIOD_W = 24,
    parameter int IDX_W    = 8,
    parameter int CARRY_W  = 16,
    parameter int NOMINAL  = 25,
    parameter int MAX_ADJ  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_cmd,
    input  logic                stop_cmd,
    input  logic [TIME_W-1:0]   sync_time,
    input  logic [TIME_W-1:0]   start_time,
    input  logic [PERIOD_W-1:0] corr_period,
    input  logic [IDX_W-1:0]    cycle_deltas,
    output logic                delta_strobe,
    output logic [IDX_W-1:0]    delta_idx,
    output logic                running
);
    logic                      launch, run, boundary;
    logic signed [CARRY_W-1:0] drift;

    sdg_ctrl #(.TIME_W(TIME_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .sync_time(sync_time), .start_time(start_time),
        .launch(launch), .run(run)
    );

    sdg_drift_meter #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W), .CARRY_W(CARRY_W)) meter_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .active(run),
        .sync_time(sync_time), .corr_period(corr_period),
        .boundary(boundary), .drift(drift)
    );

    sdg_delta_shaper #(.IDX_W(IDX_W), .CARRY_W(CARRY_W),
                       .NOMINAL(NOMINAL), .MAX_ADJ(MAX_ADJ)) shaper_i (
        .clk(clk), .rst_n(rst_n), .active(run), .halt(stop_cmd),
        .boundary(boundary), .drift(drift), .cycle_deltas(cycle_deltas),
        .strobe(delta_strobe), .idx(delta_idx)
    );

    assign running = run;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (delta_idx == '0) && !delta_strobe);

    // R2
    launch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> delta_strobe && (delta_idx == '0));
endmodule

// File: tb/sched_delta_gen_tb_top.sv
module sched_delta_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 48;
    localparam int PW = 24;
    localparam int IW = 8;

    typedef struct { int len; int idx; string req; } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_cmd = 1'b0, stop_cmd = 1'b0;
    logic [TW-1:0] sync_q = TW'(1000);
    logic [TW-1:0] start_time = '0;
    logic [PW-1:0] corr_period = PW'(100);
    logic [IW-1:0] cycle_deltas = IW'(4);
    logic          delta_strobe, running;
    logic [IW-1:0] delta_idx;

    int   checks = 0, errors = 0;
    exp_t exp_q[$];
    int   cyc = 0, last_cyc = 0, strobe_total = 0;
    int   pend_extra = 0, pend_hold = 0, extra_once = 0, hold_cnt = 0;
    int   next_idx = 0, cur_ndel = 1;
    bit   done = 0;

    sched_delta_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .sync_time(sync_q), .start_time(start_time), .corr_period(corr_period),
        .cycle_deltas(cycle_deltas), .delta_strobe(delta_strobe),
        .delta_idx(delta_idx), .running(running)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected strobes and compares; then advances the synchronized clock.
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (rst_n && delta_strobe) begin
            strobe_total++;
            if (exp_q.size() == 0) begin
                chk(0, "R3", "unexpected strobe at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                if (e.len < 0) begin
                    chk(sync_q == start_time, "R2", "sync at launch", longint'(sync_q), longint'(start_time));
                    chk(running == 1'b1, "R2", "running at launch", running, 1);
                    extra_once = pend_extra;
                    hold_cnt   = pend_hold;
                end else begin
                    chk(cyc - last_cyc == e.len, e.req, "delta length", cyc - last_cyc, e.len);
                end
                chk(int'(delta_idx) == e.idx, "R4", "delta index", delta_idx, e.idx);
            end
            last_cyc = cyc;
        end
        if (hold_cnt > 0) hold_cnt--;
        else begin
            sync_q = sync_q + TW'(1 + extra_once);
            extra_once = 0;
        end
    end

    task automatic push_len(input int len, input string req);
        exp_t e;
        e.len = len; e.idx = next_idx; e.req = req;
        exp_q.push_back(e);
        next_idx = (next_idx + 1) % cur_ndel;
    endtask

    task automatic arm_run(input int ndel, input int per, input int extra, input int hold);
        exp_t e;
        cur_ndel = ndel; cycle_deltas = IW'(ndel); corr_period = PW'(per);
        pend_extra = extra; pend_hold = hold;
        e.len = -1; e.idx = 0; e.req = "R2";
        exp_q.push_back(e);
        next_idx = 1 % ndel;
        @(negedge clk);
        start_time = sync_q + TW'(20);
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        @(negedge clk);
        chk(running == 1'b0, "R2", "running before start time", running, 0);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, "R3", "expected strobes left", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic stop_and_check();
        int s;
        @(negedge clk) stop_cmd = 1'b1;
        @(negedge clk) stop_cmd = 1'b0;
        chk(running == 1'b0, "R8", "running after stop", running, 0);
        chk(delta_idx == '0, "R8", "index after stop", delta_idx, 0);
        chk(delta_strobe == 1'b0, "R8", "strobe after stop", delta_strobe, 0);
        s = strobe_total;
        repeat (60) @(negedge clk);
        chk(strobe_total == s, "R8", "strobes while stopped", strobe_total - s, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "R3", "watchdog expired", cyc, 0);
        finish_sim();
    end

    initial begin
        int s;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(running == 1'b0, "R1", "running in reset", running, 0);
        chk(delta_strobe == 1'b0, "R1", "strobe in reset", delta_strobe, 0);
        chk(delta_idx == '0, "R1", "index in reset", delta_idx, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(running == 1'b0, "R1", "running after reset", running, 0);

        // R3 / R4: nominal deltas, 4 per cycle; R10: start while running ignored
        arm_run(4, 100, 0, 0);
        repeat (8) push_len(25, "R3");
        while (exp_q.size() > 4) @(negedge clk);
        start_cmd = 1'b1;
        @(negedge clk) start_cmd = 1'b0;
        @(negedge clk);
        chk(running == 1'b1, "R10", "running after redundant start", running, 1);
        wait_drain();
        stop_and_check();

        // R5: sync clock ahead by 3 ticks, 3 deltas per cycle
        arm_run(3, 100, 3, 0);
        repeat (4) push_len(25, "R5");
        push_len(22, "R5");
        repeat (2) push_len(25, "R5");
        wait_drain();
        stop_and_check();

        // R7: ahead by 13 ticks, clamp at 5 per delta, remainder carried
        arm_run(5, 100, 13, 0);
        repeat (4) push_len(25, "R7");
        push_len(20, "R7");
        push_len(20, "R7");
        push_len(22, "R7");
        push_len(25, "R7");
        wait_drain();
        stop_and_check();

        // R6 / R7: sync clock behind by 8 ticks, 2 deltas per cycle
        arm_run(2, 100, 0, 8);
        repeat (5) push_len(25, "R6");
        push_len(30, "R6");
        push_len(28, "R7");
        push_len(25, "R6");
        wait_drain();
        stop_and_check();

        // R9: stop while armed aborts launch
        @(negedge clk);
        start_time = sync_q + TW'(30);
        start_cmd = 1'b1;
        @(negedge clk) start_cmd = 1'b0;
        repeat (3) @(negedge clk);
        stop_cmd = 1'b1;
        @(negedge clk) stop_cmd = 1'b0;
        s = strobe_total;
        repeat (60) @(negedge clk);
        chk(running == 1'b0, "R9", "running after aborted arm", running, 0);
        chk(strobe_total == s, "R9", "strobes after aborted arm", strobe_total - s, 0);

        // R10: simultaneous start and stop in idle, start time already passed
        start_time = sync_q - TW'(5);
        start_cmd = 1'b1; stop_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; stop_cmd = 1'b0;
        repeat (10) @(negedge clk);
        chk(running == 1'b0, "R10", "running after start+stop", running, 0);
        chk(strobe_total == s, "R10", "strobes after start+stop", strobe_total - s, 0);

        finish_sim();
    end
endmodule